// File: doc/BRIEF.md
# ECC-Protected Byte-Lane Memory Core

This block is a synchronous storage core of 16-bit words. Every word is kept together with five Hamming check bits. A read returns the corrected data one clock after the request. It also reports whether a single flipped bit was repaired. The array itself is never repaired. Access is controlled by two chip selects of opposite polarity, a write strobe, an output strobe and two active-low lane enables. The upper enable covers data bits 15:8 and the lower enable covers bits 7:0.

A configuration input switches the core from word access to byte access. In byte access only the low data lane carries data. Data input bit 15 becomes one more address bit that picks the upper or lower byte of the addressed word, so the number of addressable bytes doubles. Any write that covers less than a whole word merges the new byte into the decoded (corrected) old word and re-encodes the result, all in one cycle. A test-only port flips one chosen bit of one stored word, so that correction and the error flag can be exercised.

Top module: `ecc_byte_mem`

## Requirements
- R1: An access happens only when `cs1_n` is 0 and `cs2` is 1. In any other case nothing is written, and in the next cycle `rd_data`, `lane_vld`, `err` and `err_vld` are all 0.
- R2: In word mode (`byte_mode`=0), if `hbe_n` and `lbe_n` are both 1 the core is in standby. No access happens, whatever the chip selects are, and the outputs in the next cycle are all 0.
- R3: In word mode, `hbe_n`=0 enables lane 1 (bits 15:8) and `lbe_n`=0 enables lane 0 (bits 7:0). A read returns only the enabled lanes: `lane_vld`={lane1,lane0}, and disabled lanes read as 0. A write updates only the enabled lanes.
- R4: If the core is selected and `we_n`=0, a write happens whatever `oe_n` is. A read needs `we_n`=1 and `oe_n`=0. If `we_n`=1 and `oe_n`=1, the outputs are disabled. Writes and disabled cycles leave all outputs 0 in the next cycle.
- R5: The read result appears on the outputs in the cycle after the read request, with single-bit errors corrected.
- R6: After a read, `err_vld`=1. `err`=1 if the stored 21-bit codeword had one flipped bit, whether that bit is a data bit or a check bit, and `err`=0 if it had none. When `err_vld`=0, `err` is 0.
- R7: A read never changes the stored codeword. Reading a corrupted word again reports `err`=1 again.
- R8: In byte mode, `hbe_n` and `lbe_n` are ignored. `wdata[15]` selects the upper byte (1) or the lower byte (0) of word `addr`. Write data is taken from `wdata[7:0]`. Read data appears on `rd_data[7:0]` with `rd_data[15:8]`=0 and `lane_vld`=2'b01.
- R9: A write that covers less than a whole word keeps the other byte at its corrected value and stores a fresh codeword. A later read of that word gives `err`=0.
- R10: When `inj_en`=1 and `inj_bit`<21, codeword bit `inj_bit` of word `inj_addr` is inverted. Bit `p`-1 holds Hamming position `p`, and positions 1, 2, 4, 8 and 16 are the check bits. The injection is ignored if `inj_bit`≥21 or if the same word is written in the same cycle.
- R11: After reset every output is 0, and every word reads as 0 with `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| hbe_n | input | 1 | Upper-lane enable, active low |
| lbe_n | input | 1 | Lower-lane enable, active low |
| byte_mode | input | 1 | 1 selects byte access |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; bit 15 is the byte select in byte mode |
| inj_en | input | 1 | Test-only bit-flip request |
| inj_addr | input | ADDR_W | Word to corrupt |
| inj_bit | input | 5 | Codeword bit to invert |
| rd_data | output | 16 | Corrected read data |
| lane_vld | output | 2 | Valid strobe per lane |
| err | output | 1 | Single-bit error was corrected |
| err_vld | output | 1 | `err` carries a read result |

## Verification
The assertions check on every cycle that deselect, standby, writes and disabled outputs all leave the outputs quiet. They also check that disabled lanes read as zero and that a byte-mode read presents only the low lane. On the storage side they check that a read leaves the addressed codeword untouched, that every write stores a codeword with a zero syndrome, and that an injection changes exactly one bit. Only the bench's scenarios can show that the returned values are right. That covers correction of data-bit and check-bit flips, the byte kept by a partial write, byte addressing through data bit 15, and write-over-injection priority. The bench checks these against its own model of the array.

// File: rtl/ecc_mem_pkg.sv
`timescale 1ns/1ps
package ecc_mem_pkg;

    localparam int DATA_W  = 16;
    localparam int LANE_W  = DATA_W / 2;
    localparam int CHK_W   = 5;
    localparam int CW_W    = DATA_W + CHK_W;
    localparam int BITSEL_W = $clog2(CW_W);

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [CHK_W-1:0]  syn_t;

    // decoded access for one cycle
    typedef struct packed {
        logic       sel;
        logic       act;
        logic       wr;
        logic       rd;
        logic [1:0] lanes;
        logic       hi_byte;
    } access_t;

    // registered output state
    typedef struct packed {
        data_t      rdata;
        logic [1:0] vld;
        logic       err;
        logic       err_vld;
    } out_t;

    // codeword bit p-1 holds Hamming position p; powers of two are check bits
    function automatic cw_t ham_encode(data_t d);
        cw_t cw;
        int  k;
        cw = '0;
        k  = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p-1] = d[k];
                k++;
            end
        end
        for (int c = 0; c < CHK_W; c++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (((p >> c) & 1) == 1) par ^= cw[p-1];
            end
            cw[(1 << c) - 1] = par;
        end
        return cw;
    endfunction

    function automatic syn_t ham_syndrome(cw_t cw);
        syn_t s;
        s = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (cw[p-1]) s ^= CHK_W'(p);
        end
        return s;
    endfunction

    function automatic data_t ham_extract(cw_t cw);
        data_t d;
        int    k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = cw[p-1];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
`timescale 1ns/1ps
module ecc_enc
    import ecc_mem_pkg::*;
(
    input  data_t data_i,
    output cw_t   cw_o
);
    assign cw_o = ham_encode(data_i);
endmodule

// File: rtl/ecc_dec.sv
`timescale 1ns/1ps
module ecc_dec
    import ecc_mem_pkg::*;
(
    input  cw_t   cw_i,
    output data_t data_o,
    output logic  fixed_o
);
    syn_t syn;
    cw_t  repaired;

    always_comb begin
        syn      = ham_syndrome(cw_i);
        repaired = cw_i;
        if (syn != '0 && int'(syn) <= CW_W) begin
            repaired[int'(syn) - 1] = ~cw_i[int'(syn) - 1];
        end
        data_o  = ham_extract(repaired);
        fixed_o = (syn != '0);
    end
endmodule

// File: rtl/ecc_access_dec.sv
`timescale 1ns/1ps
module ecc_access_dec
    import ecc_mem_pkg::*;
(
    input  logic    cs1_n,
    input  logic    cs2,
    input  logic    we_n,
    input  logic    oe_n,
    input  logic    hbe_n,
    input  logic    lbe_n,
    input  logic    byte_mode,
    input  logic    hi_sel,
    output access_t acc_o
);
    always_comb begin
        acc_o.sel     = !cs1_n && cs2;
        // lane enables only gate access in word mode
        acc_o.act     = acc_o.sel && (byte_mode || !(hbe_n && lbe_n));
        acc_o.wr      = acc_o.act && !we_n;
        acc_o.rd      = acc_o.act && we_n && !oe_n;
        acc_o.hi_byte = byte_mode && hi_sel;
        if (byte_mode) begin
            acc_o.lanes = hi_sel ? 2'b10 : 2'b01;
        end else begin
            acc_o.lanes = {!hbe_n, !lbe_n};
        end
    end
endmodule

// File: rtl/ecc_byte_mem.sv
`timescale 1ns/1ps
module ecc_byte_mem
    import ecc_mem_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs1_n,
    input  logic                cs2,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                hbe_n,
    input  logic                lbe_n,
    input  logic                byte_mode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [15:0]         wdata,
    input  logic                inj_en,
    input  logic [ADDR_W-1:0]   inj_addr,
    input  logic [BITSEL_W-1:0] inj_bit,
    output logic [15:0]         rd_data,
    output logic [1:0]          lane_vld,
    output logic                err,
    output logic                err_vld
);
    localparam int WORDS = 1 << ADDR_W;

    access_t acc;
    cw_t     mem_q [WORDS];
    cw_t     mem_d [WORDS];
    cw_t     rd_cw;
    data_t   old_data;
    logic    old_fixed;
    data_t   merged;
    cw_t     merged_cw;
    logic    inj_ok;
    out_t    out_d;
    out_t    out_q;

    ecc_access_dec u_acc (
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .hbe_n     (hbe_n),
        .lbe_n     (lbe_n),
        .byte_mode (byte_mode),
        .hi_sel    (wdata[15]),
        .acc_o     (acc)
    );

    assign rd_cw = mem_q[addr];

    ecc_dec u_dec (
        .cw_i    (rd_cw),
        .data_o  (old_data),
        .fixed_o (old_fixed)
    );

    // merge new lane(s) into the corrected old word
    always_comb begin
        if (byte_mode) begin
            merged = acc.hi_byte ? {wdata[LANE_W-1:0], old_data[LANE_W-1:0]}
                                 : {old_data[DATA_W-1:LANE_W], wdata[LANE_W-1:0]};
        end else begin
            merged[DATA_W-1:LANE_W] = acc.lanes[1] ? wdata[DATA_W-1:LANE_W]
                                                   : old_data[DATA_W-1:LANE_W];
            merged[LANE_W-1:0]      = acc.lanes[0] ? wdata[LANE_W-1:0]
                                                   : old_data[LANE_W-1:0];
        end
    end

    ecc_enc u_enc (
        .data_i (merged),
        .cw_o   (merged_cw)
    );

    // next state of the array and the output registers
    always_comb begin
        mem_d  = mem_q;
        inj_ok = inj_en && (int'(inj_bit) < CW_W) && !(acc.wr && inj_addr == addr);
        if (inj_ok) begin
            mem_d[inj_addr][inj_bit] = ~mem_q[inj_addr][inj_bit];
        end
        if (acc.wr) begin
            mem_d[addr] = merged_cw;
        end

        out_d = '0;
        if (acc.rd) begin
            out_d.err     = old_fixed;
            out_d.err_vld = 1'b1;
            if (byte_mode) begin
                out_d.rdata[LANE_W-1:0] = acc.hi_byte ? old_data[DATA_W-1:LANE_W]
                                                      : old_data[LANE_W-1:0];
                out_d.vld = 2'b01;
            end else begin
                out_d.rdata = old_data & {{LANE_W{acc.lanes[1]}}, {LANE_W{acc.lanes[0]}}};
                out_d.vld   = acc.lanes;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            out_q <= out_d;
            mem_q <= mem_d;
        end
    end

    assign rd_data  = out_q.rdata;
    assign lane_vld = out_q.vld;
    assign err      = out_q.err;
    assign err_vld  = out_q.err_vld;

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n || !cs2) |=> (lane_vld == 2'b00 && !err_vld && rd_data == '0)); // R1
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_mode && hbe_n && lbe_n) |=> (lane_vld == 2'b00 && !err_vld)); // R2
    AST_LANE_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_vld[1] |-> rd_data[15:8] == 8'h00); // R3
    AST_LANE_LO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_vld[0] |-> rd_data[7:0] == 8'h00); // R3
    AST_WRITE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || oe_n) |=> !err_vld); // R4
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !err_vld |-> !err); // R6
    AST_READ_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc.rd && !inj_en) |=> mem_q[$past(addr)] == $past(rd_cw)); // R7
    AST_BYTE_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && acc.rd) |=> lane_vld == 2'b01); // R8
    AST_WRITE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        acc.wr |=> ham_syndrome(mem_q[$past(addr)]) == '0); // R9
    AST_INJ_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        inj_ok |=> $countones(mem_q[$past(inj_addr)] ^ $past(mem_q[inj_addr])) == 1); // R10

endmodule

// File: tb/ecc_byte_mem_tb.sv
`timescale 1ns/1ps
module ecc_byte_mem_tb;

    localparam int ADDR_W = 6;
    localparam int WORDS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs1_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic              hbe_n = 1'b1, lbe_n = 1'b1, byte_mode = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wdata = '0;
    logic              inj_en = 1'b0;
    logic [ADDR_W-1:0] inj_addr = '0;
    logic [4:0]        inj_bit = '0;
    logic [15:0]       rd_data;
    logic [1:0]        lane_vld;
    logic              err, err_vld;

    int total = 0;
    int bad   = 0;

    logic [15:0] m_data [WORDS];
    int          m_flip [WORDS];

    always #2.5 clk = ~clk;

    ecc_byte_mem #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n),
        .oe_n(oe_n), .hbe_n(hbe_n), .lbe_n(lbe_n), .byte_mode(byte_mode),
        .addr(addr), .wdata(wdata), .inj_en(inj_en), .inj_addr(inj_addr),
        .inj_bit(inj_bit), .rd_data(rd_data), .lane_vld(lane_vld),
        .err(err), .err_vld(err_vld)
    );

    task automatic check(input string tag, input logic [15:0] e_d, input logic [1:0] e_v,
                         input logic e_e, input logic e_ev);
        total++;
        if (rd_data !== e_d || lane_vld !== e_v || err !== e_e || err_vld !== e_ev) begin
            bad++;
            $display("FAIL %s: got data=%h vld=%b err=%b ev=%b exp data=%h vld=%b err=%b ev=%b",
                     tag, rd_data, lane_vld, err, err_vld, e_d, e_v, e_e, e_ev);
        end
    endtask

    // one access: expected outputs come from the bench model, then the model updates
    task automatic op(input logic c1n, input logic c2, input logic wen, input logic oen,
                      input logic hbn, input logic lbn, input logic bm,
                      input logic [ADDR_W-1:0] a, input logic [15:0] wd,
                      input logic ie, input logic [ADDR_W-1:0] ia, input logic [4:0] ib,
                      input string tag);
        logic        sel, act, wr, rd;
        logic [15:0] e_d;
        logic [1:0]  e_v;
        logic        e_e, e_ev;
        if (ie && ib < 21 && m_flip[ia] >= 0) ie = 1'b0;
        sel = !c1n && c2;
        act = sel && (bm || !(hbn && lbn));
        wr  = act && !wen;
        rd  = act && wen && !oen;
        e_d = '0; e_v = '0; e_e = 1'b0; e_ev = 1'b0;
        if (rd) begin
            e_ev = 1'b1;
            e_e  = (m_flip[a] >= 0);
            if (bm) begin
                e_d = {8'h00, wd[15] ? m_data[a][15:8] : m_data[a][7:0]};
                e_v = 2'b01;
            end else begin
                e_d = m_data[a] & {{8{!hbn}}, {8{!lbn}}};
                e_v = {!hbn, !lbn};
            end
        end
        @(negedge clk);
        cs1_n = c1n; cs2 = c2; we_n = wen; oe_n = oen; hbe_n = hbn; lbe_n = lbn;
        byte_mode = bm; addr = a; wdata = wd; inj_en = ie; inj_addr = ia; inj_bit = ib;
        @(posedge clk);
        @(negedge clk);
        cs1_n = 1'b1; inj_en = 1'b0;
        check(tag, e_d, e_v, e_e, e_ev);
        if (wr) begin
            if (bm) begin
                if (wd[15]) m_data[a][15:8] = wd[7:0];
                else        m_data[a][7:0]  = wd[7:0];
            end else begin
                if (!hbn) m_data[a][15:8] = wd[15:8];
                if (!lbn) m_data[a][7:0]  = wd[7:0];
            end
            m_flip[a] = -1;
        end
        if (ie && ib < 21 && !(wr && ia == a)) m_flip[ia] = int'(ib);
    endtask

    task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [15:0] d, input string tag);
        op(0, 1, 0, 1, 0, 0, 0, a, d, 0, 0, 0, tag);
    endtask

    task automatic rd_word(input logic [ADDR_W-1:0] a, input string tag);
        op(0, 1, 1, 0, 0, 0, 0, a, 16'h0, 0, 0, 0, tag);
    endtask

    task automatic inject(input logic [ADDR_W-1:0] a, input logic [4:0] b, input string tag);
        op(1, 0, 1, 1, 1, 1, 0, 0, 16'h0, 1, a, b, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin m_data[i] = '0; m_flip[i] = -1; end
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check("R11 reset outputs", 16'h0, 2'b00, 1'b0, 1'b0);
        rd_word(5, "R11 reset word reads zero");

        wr_word(3, 16'hA55A, "R4 write quiet");
        rd_word(3, "R5 read back");
        op(0, 1, 0, 0, 0, 0, 0, 4, 16'h1234, 0, 0, 0, "R4 write with oe low");
        rd_word(4, "R4 read after oe-low write");
        op(0, 1, 1, 1, 0, 0, 0, 4, 16'h0, 0, 0, 0, "R4 output disabled");

        op(1, 1, 0, 1, 0, 0, 0, 3, 16'hFFFF, 0, 0, 0, "R1 cs1 high write ignored");
        op(0, 0, 0, 1, 0, 0, 0, 3, 16'hFFFF, 0, 0, 0, "R1 cs2 low write ignored");
        op(0, 0, 1, 0, 0, 0, 0, 3, 16'h0, 0, 0, 0, "R1 deselected read quiet");
        rd_word(3, "R1 word unchanged");
        op(0, 1, 0, 1, 1, 1, 0, 3, 16'h0F0F, 0, 0, 0, "R2 standby write ignored");
        op(0, 1, 1, 0, 1, 1, 0, 3, 16'h0, 0, 0, 0, "R2 standby read quiet");
        rd_word(3, "R2 word unchanged");

        op(0, 1, 1, 0, 1, 0, 0, 3, 16'h0, 0, 0, 0, "R3 low lane read");
        op(0, 1, 1, 0, 0, 1, 0, 3, 16'h0, 0, 0, 0, "R3 high lane read");
        op(0, 1, 0, 1, 0, 1, 0, 3, 16'hC3C3, 0, 0, 0, "R3 high lane write");
        rd_word(3, "R3 other lane kept");

        inject(7, 5'd0, "R10 inject");
        rd_word(7, "R6 check-bit flip flagged");
        wr_word(8, 16'hBEEF, "R10 setup");
        inject(8, 5'd9, "R10 inject data");
        rd_word(8, "R6 data-bit flip corrected");
        rd_word(8, "R7 no writeback, flag again");
        op(0, 1, 0, 1, 1, 0, 0, 8, 16'h0077, 0, 0, 0, "R9 partial write on corrupt word");
        rd_word(8, "R9 merged word clean");
        inject(9, 5'd21, "R10 out-of-range");
        rd_word(9, "R10 out-of-range ignored");
        op(0, 1, 0, 1, 0, 0, 0, 10, 16'h4242, 1, 10, 5'd3, "R10 write beats inject");
        rd_word(10, "R10 write won");

        op(0, 1, 0, 1, 1, 1, 1, 12, 16'h80AB, 0, 0, 0, "R8 byte write hi");
        op(0, 1, 0, 1, 0, 0, 1, 12, 16'h00CD, 0, 0, 0, "R8 byte write lo");
        op(0, 1, 1, 0, 1, 1, 1, 12, 16'h8000, 0, 0, 0, "R8 byte read hi");
        op(0, 1, 1, 0, 0, 1, 1, 12, 16'h0000, 0, 0, 0, "R8 byte read lo");
        rd_word(12, "R8 word view of bytes");

        for (int n = 0; n < 600; n++) begin
            logic bm, hbn, lbn, wen, oen, c1n, c2, ie;
            logic [ADDR_W-1:0] a, ia;
            logic [15:0] wd;
            logic [4:0] ib;
            c1n = ($urandom % 8) == 0;
            c2  = ($urandom % 8) != 0;
            wen = $urandom % 2;
            oen = ($urandom % 4) == 0;
            hbn = $urandom % 2;
            lbn = $urandom % 2;
            bm  = ($urandom % 4) == 0;
            a   = ADDR_W'($urandom % 16);
            wd  = 16'($urandom);
            ie  = ($urandom % 6) == 0;
            ia  = ADDR_W'($urandom % 16);
            ib  = 5'($urandom % 23);
            op(c1n, c2, wen, oen, hbn, lbn, bm, a, wd, ie, ia, ib, "R5 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule